// File: doc/BRIEF.md
# Serial Wiper Register Controller

This block is the digital core of a 1024-position digital potentiometer. A host reaches it over a four-wire serial slave link: a low-active select (`cs_n`), a serial clock (`sck`), a data input (`mosi`) and a data output (`sdo`). All inputs are brought into the fast system clock through two-flop synchronizers. Edge detection then drives a shift register, a frame bit counter and a command decoder. Those act on a 10-bit wiper register and a two-bit configuration register.

A frame is 16 bits, sent MSB first. Bits 13:10 carry the operation and bits 9:0 carry the operand. A frame takes effect only when select rises after a nonzero multiple of 16 clocks. When a longer frame is sent, its final 16 bits are the ones obeyed. Reads load the requested value into the shift register, so it comes out on `sdo` during the following frame. Any other frame leaves its own bits in the shift register, so they pass on to a chained device. The block drives the wiper code, a shutdown flag and the linearity-mode flag for the analog array, together with a completion flag.

Top module: `dpot_ctrl`

## Requirements
- R1: Frame bits are taken MSB first on each falling `sck` edge while `cs_n` is low. The operation is bits 13:10 and the operand is bits 9:0. In a 32-bit frame, the last 16 bits are executed.
- R2: A frame executes on the rising edge of `cs_n` only when the number of falling `sck` edges since `cs_n` fell is a nonzero multiple of 16. Any other frame changes no register and leaves `rdy` high.
- R3: Code 4'b0001 loads the operand into the wiper only when the write-enable bit is 1. With write-enable at 0, the wiper is left unchanged.
- R4: Code 4'b0110 copies operand bit 1 into write-enable and operand bit 2 into the mode bit. `norm_mode` shows the mode bit.
- R5: Code 4'b0100 sets the wiper to midscale 0x200, whatever the write-enable bit holds.
- R6: When `rst_n` is low, and after each rising edge of `hard_rst`, the following hold: wiper = 0x200, write-enable = 0, mode = 0, shutdown = 0, and `sdo_en` = 1.
- R7: Code 4'b1000 sets `shutdown` to operand bit 0. It does not alter the wiper, and every code is still obeyed while shutdown is set.
- R8: After code 4'b0010 the next frame shifts out {6'b0, wiper}. After code 4'b0111 it shifts out a word whose bit 2 is the mode bit and bit 1 is write-enable, with all other bits 0.
- R9: After any other executed frame or a discarded frame, `sdo` shifts out the last 16 bits received, MSB first. It updates after each rising `sck` edge, and the shift register clears to 0 at reset.
- R10: An executed frame sets `sdo_en` to 0 exactly when its code is 4'b0000 and the frame executed just before it was 16'h8001. Every other executed frame sets `sdo_en` to 1.
- R11: `rdy` falls in the cycle after a frame executes and returns high RDY_CYCLES clocks later.
- R12: Codes 4'b0000, 4'b0011, 4'b0101 and 4'b1001 to 4'b1111 change neither the wiper, the configuration nor shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hard_rst | input | 1 | Reset request; its rising edge restores the defaults |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | 1 = sdo driven, 0 = released (high impedance) |
| rdy | output | 1 | Completion flag, low while an executed frame settles |
| wiper | output | 10 | Wiper code for the resistor array |
| shutdown | output | 1 | Array shutdown request |
| norm_mode | output | 1 | 1 = normal mode, 0 = resistor-performance mode |

## Verification
The bench goes after the following corner cases, each with the wrong behaviour it would expose:
- **Frame length.** Frames of 0, 15, 17 and 31 bits must be dropped. A counter that only checks for "at least 16" would execute them.
- **32-bit frames.** A frame of 32 bits must run its second word. A design that decodes the first word would act on the wrong bits.
- **Write lock.** A wiper write while locked must do nothing. A missing lock would move the wiper, while midscale and reset must still work.
- **Readback and release.** A read answer must arrive one frame later, not in the same frame. A release sequence broken by an intervening frame must not float `sdo`.

Random frames, mixed with occasional resets, then compare every output and every bit on `sdo` against a reference model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [3:0] OP_NOP    = 4'b0000;
  localparam logic [3:0] OP_SET    = 4'b0001;
  localparam logic [3:0] OP_GET    = 4'b0010;
  localparam logic [3:0] OP_MID    = 4'b0100;
  localparam logic [3:0] OP_CFG    = 4'b0110;
  localparam logic [3:0] OP_GETCFG = 4'b0111;
  localparam logic [3:0] OP_SLEEP  = 4'b1000;
  localparam int CFG_WREN_BIT = 1;
  localparam int CFG_NORM_BIT = 2;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= INIT;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_lvl,
  input  logic          sel_fall,
  input  logic          sel_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_lvl,
  input  logic          load_en,
  input  logic [FW-1:0] load_word,
  output logic          frame_exec,
  output logic [FW-1:0] frame_word,
  output logic          sdo_bit
);
  localparam int CNTW = $clog2(FW);

  logic [FW-1:0]   sreg_q;
  logic [CNTW-1:0] cnt_q;
  logic            full_q;
  logic            sdo_q;

  function automatic logic [CNTW-1:0] cnt_next(input logic [CNTW-1:0] c);
    return (c == CNTW'(FW - 1)) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      if (sel_fall) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else if (sck_fall && !sel_lvl) begin
        sreg_q <= {sreg_q[FW-2:0], mosi_lvl};
        cnt_q  <= cnt_next(cnt_q);
        if (cnt_q == CNTW'(FW - 1)) full_q <= 1'b1;
      end
      if (load_en) sreg_q <= load_word;
      if (sck_rise && !sel_lvl) sdo_q <= sreg_q[FW-1];
    end
  end

  assign frame_exec = sel_rise && full_q && (cnt_q == '0);
  assign frame_word = sreg_q;
  assign sdo_bit    = sdo_q;

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lvl && !sel_fall) |=> $stable(sreg_q) || $past(load_en)); // R9
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int DW        = 10,
  parameter int CW        = 4,
  parameter int FW        = 16,
  parameter int RDY_DELAY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_exec,
  input  logic [FW-1:0] frame_word,
  input  logic          hw_rst_edge,
  output logic [DW-1:0] wiper,
  output logic          norm,
  output logic          sleep,
  output logic          hiz,
  output logic          rdy,
  output logic          load_en,
  output logic [FW-1:0] load_word
);
  localparam logic [DW-1:0] MID     = DW'(1) << (DW - 1);
  localparam logic [FW-1:0] HIZ_KEY = (FW'(1) << (FW - 1)) | FW'(1);
  localparam int            BW      = $clog2(RDY_DELAY + 1);

  logic [DW-1:0] wiper_q;
  logic          wren_q, norm_q, sleep_q, hiz_q, armed_q, rdy_q;
  logic [BW-1:0] busy_q;
  logic [CW-1:0] cmd;
  logic [DW-1:0] dat;
  logic          run;

  function automatic logic [FW-1:0] pad_word(input logic [DW-1:0] v);
    return FW'(v);
  endfunction

  function automatic logic [DW-1:0] cfg_image(input logic n, input logic w);
    logic [DW-1:0] v;
    v = '0;
    v[CFG_NORM_BIT] = n;
    v[CFG_WREN_BIT] = w;
    return v;
  endfunction

  assign cmd = frame_word[DW +: CW];
  assign dat = frame_word[DW-1:0];
  assign run = frame_exec && !hw_rst_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= MID;
      wren_q  <= 1'b0;
      norm_q  <= 1'b0;
      sleep_q <= 1'b0;
      hiz_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (hw_rst_edge) begin
      wiper_q <= MID;
      wren_q  <= 1'b0;
      norm_q  <= 1'b0;
      sleep_q <= 1'b0;
      hiz_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (frame_exec) begin
      hiz_q   <= armed_q && (cmd == CW'(OP_NOP));
      armed_q <= (frame_word == HIZ_KEY);
      case (cmd)
        CW'(OP_SET):   if (wren_q) wiper_q <= dat;
        CW'(OP_MID):   wiper_q <= MID;
        CW'(OP_CFG): begin
          wren_q <= dat[CFG_WREN_BIT];
          norm_q <= dat[CFG_NORM_BIT];
        end
        CW'(OP_SLEEP): sleep_q <= dat[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      busy_q <= '0;
    end else if (frame_exec) begin
      rdy_q  <= 1'b0;
      busy_q <= BW'(RDY_DELAY);
    end else if (busy_q != '0) begin
      busy_q <= busy_q - 1'b1;
      if (busy_q == BW'(1)) rdy_q <= 1'b1;
    end
  end

  always_comb begin
    load_en   = run && (cmd == CW'(OP_GET) || cmd == CW'(OP_GETCFG));
    load_word = (cmd == CW'(OP_GET)) ? pad_word(wiper_q)
                                     : pad_word(cfg_image(norm_q, wren_q));
  end

  assign wiper = wiper_q;
  assign norm  = norm_q;
  assign sleep = sleep_q;
  assign hiz   = hiz_q;
  assign rdy   = rdy_q;

  AST_WIPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_exec && !hw_rst_edge) |=> $stable(wiper_q)); // R2
  AST_WIPER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd == CW'(OP_SET) && !wren_q) |=> $stable(wiper_q)); // R3
  AST_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd == CW'(OP_MID)) |=> (wiper_q == MID)); // R5
  AST_HARD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst_edge |=> (wiper_q == MID && !wren_q && !norm_q && !sleep_q && !hiz_q)); // R6
  AST_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd == CW'(OP_SLEEP)) |=> $stable(wiper_q)); // R7
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_exec |=> !rdy_q); // R11
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
  parameter int WIPER_BITS  = 10,
  parameter int CMD_BITS    = 4,
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RDY_CYCLES  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hard_rst,
  input  logic                  cs_n,
  input  logic                  sck,
  input  logic                  mosi,
  output logic                  sdo,
  output logic                  sdo_en,
  output logic                  rdy,
  output logic [WIPER_BITS-1:0] wiper,
  output logic                  shutdown,
  output logic                  norm_mode
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] IDLE = 4'b0001;

  logic [NSYNC-1:0] raw, lvl;
  logic [2:0]       prev_q;
  logic             sel_rise, sel_fall, sck_rise, sck_fall, rst_edge;
  logic             frame_exec, load_en, sdo_bit, hiz;
  logic [FRAME_BITS-1:0] frame_word, load_word;

  assign raw = {hard_rst, mosi, sck, cs_n};

  dpot_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .INIT(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw), .lvl(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {1'b0, 1'b0, 1'b1};
    else        prev_q <= {lvl[3], lvl[1], lvl[0]};
  end

  assign sel_rise = lvl[0] && !prev_q[0];
  assign sel_fall = !lvl[0] && prev_q[0];
  assign sck_rise = lvl[1] && !prev_q[1];
  assign sck_fall = !lvl[1] && prev_q[1];
  assign rst_edge = lvl[3] && !prev_q[2];

  dpot_shifter #(.FW(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(lvl[0]), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_lvl(lvl[2]),
    .load_en(load_en), .load_word(load_word),
    .frame_exec(frame_exec), .frame_word(frame_word), .sdo_bit(sdo_bit)
  );

  dpot_regs #(.DW(WIPER_BITS), .CW(CMD_BITS), .FW(FRAME_BITS),
              .RDY_DELAY(RDY_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_exec(frame_exec), .frame_word(frame_word), .hw_rst_edge(rst_edge),
    .wiper(wiper), .norm(norm_mode), .sleep(shutdown), .hiz(hiz),
    .rdy(rdy), .load_en(load_en), .load_word(load_word)
  );

  assign sdo    = sdo_bit;
  assign sdo_en = !hiz;

  AST_EXEC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_exec |-> (lvl[0] && !sck_fall)); // R2
endmodule

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, hard_rst = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic sdo, sdo_en, rdy, shutdown, norm_mode;
  logic [9:0] wiper;

  int total = 0, bad = 0;
  bit done = 0;

  logic [9:0]  m_wiper;
  logic        m_wren, m_norm, m_sleep, m_hiz, m_armed;
  logic [15:0] m_sreg;

  always #5 clk = ~clk;

  dpot_ctrl i_dpot_ctrl (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .sdo(sdo), .sdo_en(sdo_en), .rdy(rdy), .wiper(wiper),
    .shutdown(shutdown), .norm_mode(norm_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_load(input logic [3:0] op);
    if (op == 4'b0010) return {6'd0, m_wiper};
    return {13'd0, m_norm, m_wren, 1'b0};
  endfunction

  function automatic logic [31:0] exp_stream(input logic [15:0] old, input logic [31:0] w, input int n);
    logic [31:0] e = '0;
    for (int j = 0; j < n; j++)
      e = {e[30:0], (j < 16) ? old[15-j] : w[n-1-(j-16)]};
    return e;
  endfunction

  task automatic check_state(input string req);
    check({req, " wiper"},    32'(wiper),     32'(m_wiper));
    check({req, " shutdown"}, 32'(shutdown),  32'(m_sleep));
    check({req, " norm_mode"},32'(norm_mode), 32'(m_norm));
    check({req, " sdo_en"},   32'(sdo_en),    32'(!m_hiz));
  endtask

  task automatic model_reset();
    m_wiper = 10'h200; m_wren = 0; m_norm = 0; m_sleep = 0; m_hiz = 0; m_armed = 0;
  endtask

  task automatic frame(input int n, input logic [31:0] w, input string req);
    logic [31:0] rx = '0;
    logic [15:0] old = m_sreg, fw;
    logic        hiz_before = m_hiz, ex;
    logic [3:0]  op;
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i]; sck = 1'b1;
      repeat (6) @(negedge clk);
      rx = {rx[30:0], sdo};
      sck = 1'b0;
      repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    ex = (n > 0) && (n % 16 == 0);
    check({req, " R11 R2 rdy after select rise"}, 32'(rdy), 32'(!ex));
    for (int i = n - 1; i >= 0; i--) m_sreg = {m_sreg[14:0], w[i]};
    if (n > 0 && !hiz_before) check({req, " R9 R8 sdo stream"}, rx, exp_stream(old, w, n));
    if (ex) begin
      fw = m_sreg; op = fw[13:10];
      m_hiz = m_armed && (op == 4'b0000);
      m_armed = (fw == 16'h8001);
      case (op)
        4'b0001: if (m_wren) m_wiper = fw[9:0];
        4'b0100: m_wiper = 10'h200;
        4'b0110: begin m_wren = fw[1]; m_norm = fw[2]; end
        4'b1000: m_sleep = fw[0];
        4'b0010, 4'b0111: m_sreg = exp_load(op);
        default: ;
      endcase
    end
    repeat (30) @(negedge clk);
    check({req, " R11 rdy back high"}, 32'(rdy), 32'd1);
    check_state(req);
  endtask

  task automatic pulse_hard_rst();
    @(negedge clk) hard_rst = 1'b1;
    repeat (6) @(negedge clk);
    model_reset();
    check_state("R6 hard_rst");
    hard_rst = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int seed, r, n;
    logic [3:0] op;
    logic [31:0] w;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    m_sreg = '0;
    repeat (5) @(negedge clk);
    check_state("R6 power-on");
    check("R11 power-on rdy", 32'(rdy), 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    frame(16, 32'h0500, "R3 locked write");
    frame(16, 32'h1802, "R4 enable write");
    frame(16, 32'h0500, "R3 write 0x100");
    frame(16, 32'h0800, "R8 read wiper");
    frame(16, 32'h0000, "R8 wiper readback");
    frame(16, 32'h1806, "R4 set mode");
    frame(16, 32'h1C00, "R8 read config");
    frame(16, 32'h0000, "R8 config readback");
    frame(16, 32'h2001, "R7 enter shutdown");
    frame(16, 32'h07FF, "R7 write in shutdown");
    frame(16, 32'h2000, "R7 leave shutdown");
    frame(16, 32'h1000, "R5 midscale");
    frame(15, 32'h0455, "R2 15 bits");
    frame(17, 32'h00455, "R2 17 bits");
    frame(0,  32'h0, "R2 no clocks");
    frame(32, 32'h1802_0533, "R1 32-bit frame");
    frame(16, 32'h3C00, "R12 unused code");
    frame(16, 32'h8001, "R10 arm release");
    frame(16, 32'h0000, "R10 release sdo");
    frame(16, 32'h0000, "R10 re-enable sdo");
    frame(16, 32'h8001, "R10 arm again");
    frame(16, 32'h0400, "R10 broken sequence");
    frame(16, 32'h1802, "R4 enable before reset");
    pulse_hard_rst();
    frame(16, 32'h0555, "R3 locked after reset");

    for (int k = 0; k < 220; k++) begin
      r = $urandom_range(0, 99);
      case ($urandom_range(0, 9))
        0: op = 4'b0000; 1, 2: op = 4'b0001; 3: op = 4'b0010; 4: op = 4'b0100;
        5: op = 4'b0110; 6: op = 4'b0111; 7: op = 4'b1000;
        default: op = 4'($urandom_range(0, 15));
      endcase
      w = {$urandom(), 2'b00, op, 10'($urandom())} ;
      w[15:0] = {2'b00, op, 10'($urandom())};
      if ($urandom_range(0, 19) == 0) w[15:0] = 16'h8001;
      if (r < 70) n = 16;
      else if (r < 82) n = 32;
      else n = $urandom_range(0, 31);
      if (n == 32) w[31:16] = {2'b00, 4'b0110, 10'($urandom())};
      frame(n, w, "R1 random");
      if ($urandom_range(0, 39) == 0) pulse_hard_rst();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule